// File: doc/BRIEF.md
# Double-Wave Time-Redundant Multiply-Add Pipeline

This block wraps a pipelined multiply-add unit and guards it against transient and intermittent faults by running each operation through the pipeline twice. An accepted operand set is kept in an input latch for two consecutive cycles. Two identical waves therefore enter the pipeline one right after the other. Each wave carries a tag bit that marks it as the first or the second copy.

At the far end of the pipeline, the first wave's result is kept in a holding register. When the second wave arrives, the two results are compared. The block then gives out the second wave's result for one cycle, together with a mismatch flag. A replay mechanism outside the block can act on that flag.

Input uses a valid/ready handshake, so the block accepts at most one operation every two cycles. A two-bit fault-injection field travels with each operation. It flips one chosen result bit in the first wave, the second wave, or both, so that detection can be exercised.

Top module: `dwave_unit`

## Requirements
- R1: `in_ready` is low in the cycle right after an operation is accepted and high again in the cycle after that, so at most one operation is accepted in any two consecutive cycles.
- R2: For accepted operands a, b and c, `out_res` equals (a*b + c) modulo 2^(2*DATA_W) when no fault is injected.
- R3: Each accepted operation produces exactly one single-cycle `out_valid` pulse. The pulse arrives STAGES+2 clock edges after the accepting edge, and only after the second wave has left the pipeline.
- R4: With no fault injected, `out_err` is 0 on every result.
- R5: Setting `in_inj[0]` flips bit INJ_BIT of the first wave's result only. `out_err` is then 1 and `out_res` still carries the correct value.
- R6: Setting `in_inj[1]` flips bit INJ_BIT of the second wave's result only. `out_err` is then 1 and `out_res` is the correct value with bit INJ_BIT inverted.
- R7: Setting both `in_inj` bits corrupts both waves the same way. `out_err` is then 0 and `out_res` is the correct value with bit INJ_BIT inverted; a common-mode fault is not detected.
- R8: A synchronous, active-high `rst` clears the input latch, every wave tag and the holding register. After reset `in_ready` is 1, and no `out_valid` appears for an operation that was in flight when reset was applied.
- R9: While `in_ready` is low, `in_valid` and the operand inputs are ignored. If `in_valid` is held high continuously, exactly one operation is accepted every two cycles, each from the operands present at its accepting edge.
- R10: The latched operands stay unchanged across both waves, so operand changes during the second issue cycle do not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can accept an operand set |
| in_a | input | DATA_W | Multiplicand |
| in_b | input | DATA_W | Multiplier |
| in_c | input | 2*DATA_W | Addend |
| in_inj | input | 2 | Fault injection: bit 0 corrupts the first wave, bit 1 corrupts the second wave |
| out_valid | output | 1 | One-cycle result strobe |
| out_res | output | 2*DATA_W | Second-wave result |
| out_err | output | 1 | The two wave results differ |

## Verification
The bench builds the block with DATA_W=8, STAGES=4 and INJ_BIT=11. Four stages force the generated delay section of the pipeline to exist, so the measured STAGES+2 latency covers a stage that the default build also uses. Bit 11 sits in the upper byte of the 16-bit result, where a flip cannot be confused with a low-order arithmetic slip. The 8-bit operands also allow all-ones inputs whose sum wraps the result width.

// File: rtl/dwave_pkg.sv
package dwave_pkg;

   // Tag carried by each copy of an operation through the pipeline.
   typedef enum logic {
      WAVE_FIRST  = 1'b0,
      WAVE_SECOND = 1'b1
   } wave_e;

   // Select which injection bit applies to a wave.
   function automatic logic inj_for_wave(input logic tag, input logic [1:0] inj);
      return (tag == WAVE_SECOND) ? inj[1] : inj[0];
   endfunction

endpackage

// File: rtl/dwave_issue.sv
module dwave_issue
   import dwave_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int RES_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [RES_W-1:0]  in_c,
   input  logic [1:0]        in_inj,
   output logic              lat_v,
   output logic              lat_tag,
   output logic [DATA_W-1:0] lat_a,
   output logic [DATA_W-1:0] lat_b,
   output logic [RES_W-1:0]  lat_c,
   output logic [1:0]        lat_inj
);

   if (DATA_W < 2) begin : g_bad_w
      $error("dwave_issue: DATA_W must be at least 2");
   end

   logic take;

   // A first wave is in the latch: the second copy goes out next cycle.
   assign in_ready = !(lat_v && lat_tag == WAVE_FIRST);
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_v   <= 1'b0;
         lat_tag <= WAVE_FIRST;
         lat_a   <= '0;
         lat_b   <= '0;
         lat_c   <= '0;
         lat_inj <= '0;
      end else if (lat_v && lat_tag == WAVE_FIRST) begin
         lat_tag <= WAVE_SECOND;
      end else if (take) begin
         lat_v   <= 1'b1;
         lat_tag <= WAVE_FIRST;
         lat_a   <= in_a;
         lat_b   <= in_b;
         lat_c   <= in_c;
         lat_inj <= in_inj;
      end else begin
         lat_v   <= 1'b0;
         lat_tag <= WAVE_FIRST;
      end
   end

   assert_ready_drop_R1: assert property (@(posedge clk) disable iff (rst)
      take |=> !in_ready);

   assert_latch_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (lat_v && lat_tag == WAVE_FIRST) |=>
         (lat_v && lat_tag == WAVE_SECOND && $stable(lat_a) && $stable(lat_b)
          && $stable(lat_c) && $stable(lat_inj)));

endmodule

// File: rtl/dwave_pipe.sv
module dwave_pipe
   import dwave_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int RES_W   = 2 * DATA_W,
   parameter int STAGES  = 3,
   parameter int INJ_BIT = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lat_v,
   input  logic              lat_tag,
   input  logic [DATA_W-1:0] lat_a,
   input  logic [DATA_W-1:0] lat_b,
   input  logic [RES_W-1:0]  lat_c,
   input  logic [1:0]        lat_inj,
   output logic              p_v,
   output logic              p_tag,
   output logic [RES_W-1:0]  p_res
);

   localparam int EXTRA = STAGES - 2;
   localparam logic [RES_W-1:0] FLIP_MASK = RES_W'(1) << INJ_BIT;

   if (STAGES < 2) begin : g_bad_st
      $error("dwave_pipe: STAGES must be at least 2");
   end
   if (INJ_BIT >= RES_W) begin : g_bad_inj
      $error("dwave_pipe: INJ_BIT outside the result");
   end

   // Stage 1: multiply.
   logic             s1_v, s1_tag;
   logic [1:0]       s1_inj;
   logic [RES_W-1:0] s1_prod, s1_c;

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_v    <= 1'b0;
         s1_tag  <= WAVE_FIRST;
         s1_inj  <= '0;
         s1_prod <= '0;
         s1_c    <= '0;
      end else begin
         s1_v    <= lat_v;
         s1_tag  <= lat_tag;
         s1_inj  <= lat_inj;
         s1_prod <= RES_W'(lat_a) * RES_W'(lat_b);
         s1_c    <= lat_c;
      end
   end

   // Stage 2: accumulate.
   logic             s2_v, s2_tag;
   logic [1:0]       s2_inj;
   logic [RES_W-1:0] s2_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         s2_v   <= 1'b0;
         s2_tag <= WAVE_FIRST;
         s2_inj <= '0;
         s2_res <= '0;
      end else begin
         s2_v   <= s1_v;
         s2_tag <= s1_tag;
         s2_inj <= s1_inj;
         s2_res <= s1_prod + s1_c;
      end
   end

   logic             end_v, end_tag;
   logic [1:0]       end_inj;
   logic [RES_W-1:0] end_res;

   if (EXTRA == 0) begin : g_nodly
      assign end_v   = s2_v;
      assign end_tag = s2_tag;
      assign end_inj = s2_inj;
      assign end_res = s2_res;
   end else begin : g_dly
      for (genvar i = 0; i < EXTRA; i++) begin : g_st
         logic             src_v, src_tag;
         logic [1:0]       src_inj;
         logic [RES_W-1:0] src_res;
         logic             q_v, q_tag;
         logic [1:0]       q_inj;
         logic [RES_W-1:0] q_res;

         if (i == 0) begin : g_src
            assign src_v   = s2_v;
            assign src_tag = s2_tag;
            assign src_inj = s2_inj;
            assign src_res = s2_res;
         end else begin : g_src
            assign src_v   = g_st[i-1].q_v;
            assign src_tag = g_st[i-1].q_tag;
            assign src_inj = g_st[i-1].q_inj;
            assign src_res = g_st[i-1].q_res;
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               q_v   <= 1'b0;
               q_tag <= WAVE_FIRST;
               q_inj <= '0;
               q_res <= '0;
            end else begin
               q_v   <= src_v;
               q_tag <= src_tag;
               q_inj <= src_inj;
               q_res <= src_res;
            end
         end
      end
      assign end_v   = g_st[EXTRA-1].q_v;
      assign end_tag = g_st[EXTRA-1].q_tag;
      assign end_inj = g_st[EXTRA-1].q_inj;
      assign end_res = g_st[EXTRA-1].q_res;
   end

   // Fault injection acts on one wave's result at the pipeline exit.
   assign p_v   = end_v;
   assign p_tag = end_tag;
   assign p_res = inj_for_wave(end_tag, end_inj) ? (end_res ^ FLIP_MASK) : end_res;

   assert_wave_order_R3: assert property (@(posedge clk) disable iff (rst)
      (p_v && p_tag == WAVE_SECOND) |-> $past(p_v && p_tag == WAVE_FIRST));

endmodule

// File: rtl/dwave_compare.sv
module dwave_compare
   import dwave_pkg::*;
#(
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             p_v,
   input  logic             p_tag,
   input  logic [RES_W-1:0] p_res,
   output logic             out_valid,
   output logic [RES_W-1:0] out_res,
   output logic             out_err
);

   logic             hold_v;
   logic [RES_W-1:0] hold_res;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_v    <= 1'b0;
         hold_res  <= '0;
         out_valid <= 1'b0;
         out_res   <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         if (p_v && p_tag == WAVE_FIRST) begin
            hold_v   <= 1'b1;
            hold_res <= p_res;
         end else if (p_v && p_tag == WAVE_SECOND) begin
            hold_v    <= 1'b0;
            out_valid <= hold_v;
            out_res   <= p_res;
            out_err   <= (p_res != hold_res);
         end
      end
   end

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_after_second_R3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(p_v && p_tag == WAVE_SECOND));

   assert_first_held_R5: assert property (@(posedge clk) disable iff (rst)
      (p_v && p_tag == WAVE_FIRST) |=> hold_v);

endmodule

// File: rtl/dwave_unit.sv
module dwave_unit
   import dwave_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int STAGES  = 3,
   parameter int INJ_BIT = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic [DATA_W-1:0]     in_a,
   input  logic [DATA_W-1:0]     in_b,
   input  logic [2*DATA_W-1:0]   in_c,
   input  logic [1:0]            in_inj,
   output logic                  out_valid,
   output logic [2*DATA_W-1:0]   out_res,
   output logic                  out_err
);

   localparam int RES_W = 2 * DATA_W;

   logic              lat_v, lat_tag;
   logic [DATA_W-1:0] lat_a, lat_b;
   logic [RES_W-1:0]  lat_c;
   logic [1:0]        lat_inj;
   logic              p_v, p_tag;
   logic [RES_W-1:0]  p_res;

   dwave_issue #(.DATA_W(DATA_W), .RES_W(RES_W)) u_issue (
      .clk(clk), .rst(rst),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_inj(in_inj),
      .lat_v(lat_v), .lat_tag(lat_tag),
      .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .lat_inj(lat_inj)
   );

   dwave_pipe #(.DATA_W(DATA_W), .RES_W(RES_W), .STAGES(STAGES), .INJ_BIT(INJ_BIT)) u_pipe (
      .clk(clk), .rst(rst),
      .lat_v(lat_v), .lat_tag(lat_tag),
      .lat_a(lat_a), .lat_b(lat_b), .lat_c(lat_c), .lat_inj(lat_inj),
      .p_v(p_v), .p_tag(p_tag), .p_res(p_res)
   );

   dwave_compare #(.RES_W(RES_W)) u_cmp (
      .clk(clk), .rst(rst),
      .p_v(p_v), .p_tag(p_tag), .p_res(p_res),
      .out_valid(out_valid), .out_res(out_res), .out_err(out_err)
   );

endmodule

// File: tb/dwave_unit_bench.sv
module dwave_unit_bench;
   localparam int DW = 8;
   localparam int ST = 4;
   localparam int IB = 11;
   localparam int RW = 2 * DW;
   localparam logic [RW-1:0] FLIP = RW'(1) << IB;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [DW-1:0] in_a = '0, in_b = '0;
   logic [RW-1:0] in_c = '0;
   logic [1:0]    in_inj = '0;
   logic          out_valid;
   logic [RW-1:0] out_res;
   logic          out_err;

   always #10 clk = ~clk;

   dwave_unit #(.DATA_W(DW), .STAGES(ST), .INJ_BIT(IB)) u_dwave_unit (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_inj(in_inj),
      .out_valid(out_valid), .out_res(out_res), .out_err(out_err)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int            n_log = 0;
   logic [RW-1:0] log_res [64];
   logic          log_err [64];
   int            log_cyc [64];

   always @(negedge clk) begin
      if (!rst && out_valid === 1'b1 && n_log < 64) begin
         log_res[n_log] = out_res;
         log_err[n_log] = out_err;
         log_cyc[n_log] = cyc;
         n_log = n_log + 1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [RW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                            input logic [RW-1:0] c);
      logic [RW-1:0] p;
      p = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
      return p + c;
   endfunction

   // Offer one operation; returns the cycle count right after the accepting edge.
   task automatic issue(input logic [DW-1:0] a, input logic [DW-1:0] b,
                        input logic [RW-1:0] c, input logic [1:0] inj, output int acc);
      @(negedge clk);
      in_valid = 1'b1; in_a = a; in_b = b; in_c = c; in_inj = inj;
      while (in_ready !== 1'b1) @(negedge clk);
      @(posedge clk);
      #1 acc = cyc;
      @(negedge clk);
      in_valid = 1'b0; in_inj = 2'b00;
      chk(in_ready === 1'b0, "R1", "ready after accept", in_ready, 0);
      @(negedge clk);
      chk(in_ready === 1'b1, "R1", "ready one cycle later", in_ready, 1);
   endtask

   task automatic t_single(input logic [DW-1:0] a, input logic [DW-1:0] b,
                           input logic [RW-1:0] c, input logic [1:0] inj,
                           input logic [RW-1:0] exp_res, input logic exp_err,
                           input string req);
      int base, acc;
      base = n_log;
      issue(a, b, c, inj, acc);
      repeat (ST + 6) @(negedge clk);
      chk(n_log == base + 1, "R3", "one pulse per operation", n_log - base, 1);
      if (n_log == base + 1) begin
         chk(log_res[base] === exp_res, req, "result", log_res[base], exp_res);
         chk(log_err[base] === exp_err, req, "error flag", log_err[base], exp_err);
         chk(log_cyc[base] - acc == ST + 2, "R3", "latency", log_cyc[base] - acc, ST + 2);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(in_ready === 1'b1, "R8", "ready after reset", in_ready, 1);
      chk(out_valid === 1'b0, "R8", "no valid after reset", out_valid, 0);
   endtask

   task automatic t_basic();
      t_single(8'd3, 8'd5, 16'd7, 2'b00, model(8'd3, 8'd5, 16'd7), 1'b0, "R2");
      t_single(8'hFF, 8'hFF, 16'hFFFF, 2'b00, model(8'hFF, 8'hFF, 16'hFFFF), 1'b0, "R2");
      t_single(8'd0, 8'd77, 16'h1234, 2'b00, 16'h1234, 1'b0, "R4");
      t_single(8'd128, 8'd2, 16'd1, 2'b00, 16'h0101, 1'b0, "R4");
   endtask

   task automatic t_inj_first();
      t_single(8'd9, 8'd11, 16'd4, 2'b01, model(8'd9, 8'd11, 16'd4), 1'b1, "R5");
   endtask

   task automatic t_inj_second();
      t_single(8'd9, 8'd11, 16'd4, 2'b10, model(8'd9, 8'd11, 16'd4) ^ FLIP, 1'b1, "R6");
   endtask

   task automatic t_inj_both();
      t_single(8'd200, 8'd3, 16'h0800, 2'b11, model(8'd200, 8'd3, 16'h0800) ^ FLIP, 1'b0, "R7");
   endtask

   task automatic t_stream();
      logic [RW-1:0] exp_q [8];
      int n_acc, base;
      n_acc = 0;
      base = n_log;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_a = DW'(i * 17 + 3);
         in_b = DW'(i * 29 + 1);
         in_c = RW'(i * 1000 + 5);
         in_inj = 2'b00;
         if (in_ready === 1'b1 && n_acc < 8) begin
            exp_q[n_acc] = model(in_a, in_b, in_c);
            n_acc++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (ST + 6) @(negedge clk);
      chk(n_acc == 5, "R1", "accepts in ten cycles", n_acc, 5);
      chk(n_log - base == n_acc, "R9", "results from stream", n_log - base, n_acc);
      for (int k = 0; k < 5; k++) begin
         if (k < n_acc && base + k < n_log)
            chk(log_res[base+k] === exp_q[k], "R10", "stream result", log_res[base+k], exp_q[k]);
      end
   endtask

   task automatic t_reset_flight();
      int base, acc;
      base = n_log;
      issue(8'd5, 8'd6, 16'd7, 2'b00, acc);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      repeat (ST + 8) @(negedge clk);
      chk(n_log == base, "R8", "in-flight op dropped", n_log - base, 0);
      chk(in_ready === 1'b1, "R8", "ready after mid reset", in_ready, 1);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_inj_first();
      t_inj_second();
      t_inj_both();
      t_stream();
      t_reset_flight();
      t_single(8'd7, 8'd7, 16'd1, 2'b00, 16'd50, 1'b0, "R2");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule